// File: doc/BRIEF.md
# Fan Spin-Up Sequencer

A fan that is at rest may not start turning if it is given a reduced supply voltage. This block watches the commanded drive for one fan and detects when the fan is being started from rest. It then replaces the commanded drive with full scale until the fan has turned far enough to produce two tachometer pulses, or until a maximum time runs out, whichever comes first. After that the commanded drive passes through unchanged.

The maximum time comes from a 2-bit mode value. At reset the mode is loaded from a three-state strap: ground, floating or high, encoded on a 2-bit input. After reset a write strobe can replace the mode at any time. Time is measured in ticks that are divided down from the system clock, so the fan-scale timeouts (half a second and up) map to a parameterised number of clock cycles. The tachometer input is the already filtered edge pulse. Measuring fan speed and ramping the drive are handled elsewhere.

All pins are plain control and status signals. There is no streaming data path, so there is no valid/ready handshake and no back-pressure.

Top module: `fan_spinup_seq`

## Requirements
- R1: While `rst_n` is low, `spin_active` is 0 and `drive_out` equals `drive_cmd`. At reset the mode is loaded from `strap_code`:
  - 2'b00 (ground) gives mode 00.
  - 2'b01 (floating) gives mode 01.
  - 2'b10 and 2'b11 (high) give mode 10.
- R2: A start occurs at a rising clock edge in one of two cases:
  - `drive_cmd` is nonzero and was zero at the previous edge.
  - It is the first edge after reset and `drive_cmd` is nonzero.
  
  A change from one nonzero value to another is not a start. If the mode is nonzero, `spin_active` is 1 from the start edge onward.
- R3: While `spin_active` is 1 and `drive_cmd` is nonzero, `full_req` is 1 and `drive_out` is all ones. Otherwise `full_req` is 0 and `drive_out` equals `drive_cmd`.
- R4: The override ends at the edge that samples the second `tach_edge` pulse after the start edge. A pulse sampled at the start edge itself is not counted, and the pulse count is cleared at every start.
- R5: With no tach pulses, `spin_active` stays 1 for exactly L clock cycles after the start edge, where L = TICK_DIV × T and T depends on the mode:
  - Mode 01: T = HALF_TICKS.
  - Mode 10: T = 2×HALF_TICKS.
  - Mode 11: T = 4×HALF_TICKS.
- R6: When the mode is 00, a start produces no override and `drive_out` follows `drive_cmd`.
- R7: A write (`mode_wr_en` = 1) replaces the mode at that edge, and the new mode applies to later starts. A write of 00 while the override is active ends the override at that same edge.
- R8: If `drive_cmd` becomes zero while the override is active, `drive_out` is 0 at once, the override ends at the next edge, and only a new zero-to-nonzero change restarts it.
- R9: The override ends at the earliest of three events: the second tach pulse, the timeout, or an abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| strap_code | input | 2 | Three-state strap: 00 ground, 01 floating, 10/11 high |
| mode_wr_en | input | 1 | Mode write strobe |
| mode_wr_val | input | 2 | Mode value: 00 off, 01 short, 10 medium, 11 long |
| drive_cmd | input | DRV_W | Commanded fan drive from the normal path |
| tach_edge | input | 1 | One-cycle pulse per filtered tachometer edge |
| spin_active | output | 1 | Spin-up override in progress |
| full_req | output | 1 | Full-scale drive requested this cycle |
| drive_out | output | DRV_W | Drive sent to the fan: all ones during the override, otherwise `drive_cmd` |

## Verification
The assertions rely on three assumptions about the inputs:
- `tach_edge` is a single-cycle pulse.
- `strap_code` is stable while reset is held.
- Inputs change only away from the sampling edge.

The stimulus keeps to these assumptions. It drives every input on the falling clock edge, raises `tach_edge` for exactly one cycle at a time, and sets the strap before reset is asserted and holds it until after reset is released.

Random sequences choose the mode, the drive value and the tach pulse times. Directed cases cover the power-up start for each strap value, a tach pulse coinciding with the start edge, an abort by a mode write, a drop of the drive command to zero, and a change from one nonzero drive value to another.

// File: rtl/fsu_pkg.sv
`timescale 1ns/1ps
package fsu_pkg;

  typedef enum logic [1:0] {
    SPIN_OFF  = 2'b00,
    SPIN_HALF = 2'b01,
    SPIN_ONE  = 2'b10,
    SPIN_TWO  = 2'b11
  } spin_mode_e;

  // Three-state strap: low -> off, floating -> short, high (either code) -> medium
  function automatic spin_mode_e strap_to_mode(input logic [1:0] code);
    case (code)
      2'b00:   return SPIN_OFF;
      2'b01:   return SPIN_HALF;
      default: return SPIN_ONE;
    endcase
  endfunction

endpackage

// File: rtl/fsu_mode_reg.sv
`timescale 1ns/1ps
module fsu_mode_reg
  import fsu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] strap_code,
  input  logic       wr_en,
  input  logic [1:0] wr_val,
  output spin_mode_e eff_mode
);

  spin_mode_e mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     mode_q <= strap_to_mode(strap_code);
    else if (wr_en) mode_q <= spin_mode_e'(wr_val);
  end

  // a write takes effect in the same cycle so an abort is immediate
  assign eff_mode = wr_en ? spin_mode_e'(wr_val) : mode_q;

  // R7
  mode_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && wr_en) |=> (mode_q == spin_mode_e'($past(wr_val))));

endmodule

// File: rtl/fsu_start_det.sv
`timescale 1ns/1ps
module fsu_start_det #(
  parameter int DRV_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DRV_W-1:0] drive_cmd,
  output logic             drive_zero,
  output logic             start
);

  logic prev_zero_q;

  assign drive_zero = (drive_cmd == '0);

  // held at one through reset, so a nonzero drive at release counts as a start
  always_ff @(posedge clk) begin
    if (!rst_n) prev_zero_q <= 1'b1;
    else        prev_zero_q <= drive_zero;
  end

  assign start = prev_zero_q && !drive_zero;

endmodule

// File: rtl/fsu_timer.sv
`timescale 1ns/1ps
module fsu_timer #(
  parameter int TICK_DIV = 8,
  parameter int CNT_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);

  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic             div_last;
  logic [CNT_W-1:0] ticks_q;

  if (TICK_DIV == 1) begin : g_nodiv
    assign div_last = 1'b1;
  end else begin : g_div
    logic [DIV_W-1:0] div_q;
    always_ff @(posedge clk) begin
      if (!rst_n || clear) div_q <= '0;
      else if (run)        div_q <= div_last ? '0 : div_q + 1'b1;
    end
    assign div_last = (div_q == DIV_W'(TICK_DIV - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear)      ticks_q <= '0;
    else if (run && div_last) ticks_q <= ticks_q + 1'b1;
  end

  logic [CNT_W:0] ticks_nxt;
  assign ticks_nxt = {1'b0, ticks_q} + 1'b1;

  assign expired = run && ((ticks_q >= limit) ||
                           (div_last && (ticks_nxt >= {1'b0, limit})));

  // R5
  tick_within_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clear && $stable(limit) && $past(run) && !$past(expired))
      |-> (ticks_q <= limit));

endmodule

// File: rtl/fan_spinup_seq.sv
`timescale 1ns/1ps
module fan_spinup_seq
  import fsu_pkg::*;
#(
  parameter int DRV_W      = 9,
  parameter int TICK_DIV   = 8,
  parameter int HALF_TICKS = 4,
  parameter int END_PULSES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       strap_code,
  input  logic             mode_wr_en,
  input  logic [1:0]       mode_wr_val,
  input  logic [DRV_W-1:0] drive_cmd,
  input  logic             tach_edge,
  output logic             spin_active,
  output logic             full_req,
  output logic [DRV_W-1:0] drive_out
);

  localparam int MAX_TICKS = 4 * HALF_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);
  localparam int PC_W      = $clog2(END_PULSES + 1);
  localparam logic [DRV_W-1:0] FULL = '1;

  spin_mode_e       eff_mode;
  logic             drive_zero;
  logic             start_w;
  logic             expired;
  logic             spin_q;
  logic [PC_W-1:0]  tach_cnt_q;
  logic [CNT_W-1:0] limit;
  logic             tach_done;
  logic             stop;

  function automatic logic [CNT_W-1:0] limit_of(input spin_mode_e m);
    case (m)
      SPIN_HALF: return CNT_W'(HALF_TICKS);
      SPIN_ONE:  return CNT_W'(2 * HALF_TICKS);
      SPIN_TWO:  return CNT_W'(4 * HALF_TICKS);
      default:   return '0;
    endcase
  endfunction

  fsu_mode_reg u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .strap_code (strap_code),
    .wr_en      (mode_wr_en),
    .wr_val     (mode_wr_val),
    .eff_mode   (eff_mode)
  );

  fsu_start_det #(.DRV_W(DRV_W)) u_start (
    .clk        (clk),
    .rst_n      (rst_n),
    .drive_cmd  (drive_cmd),
    .drive_zero (drive_zero),
    .start      (start_w)
  );

  assign limit = limit_of(eff_mode);

  fsu_timer #(.TICK_DIV(TICK_DIV), .CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (start_w),
    .run     (spin_q),
    .limit   (limit),
    .expired (expired)
  );

  assign tach_done = spin_q && tach_edge && (tach_cnt_q == PC_W'(END_PULSES - 1));
  assign stop      = drive_zero || (eff_mode == SPIN_OFF) || expired || tach_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spin_q     <= 1'b0;
      tach_cnt_q <= '0;
    end else if (start_w) begin
      spin_q     <= (eff_mode != SPIN_OFF);
      tach_cnt_q <= '0;
    end else if (spin_q) begin
      if (stop)           spin_q     <= 1'b0;
      else if (tach_edge) tach_cnt_q <= tach_cnt_q + 1'b1;
    end
  end

  assign spin_active = spin_q;
  assign full_req    = spin_q && !drive_zero;
  assign drive_out   = full_req ? FULL : drive_cmd;

  // R2
  rise_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spin_q) |-> $past(start_w));

  // R4
  rise_clears_tach_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spin_q) |-> (tach_cnt_q == '0));

  // R4
  second_tach_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spin_q && !start_w && tach_edge && tach_cnt_q == PC_W'(END_PULSES - 1)) |=> !spin_q);

  // R7
  off_write_aborts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spin_q && mode_wr_en && mode_wr_val == 2'b00) |=> !spin_q);

  // R8
  zero_drive_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spin_q && drive_cmd == '0) |=> !spin_q);

  // R8
  zero_drive_passes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_cmd == '0) |-> (drive_out == '0 && !full_req));

endmodule

// File: tb/fan_spinup_seq_tb_top.sv
`timescale 1ns/1ps
module fan_spinup_seq_tb_top;

  localparam int DRV_W = 9;
  localparam int DIV   = 8;
  localparam int HALF  = 4;
  localparam int WIN   = 4 * HALF * DIV + 8;
  localparam logic [DRV_W-1:0] FULL = '1;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [1:0]       strap_code;
  logic             mode_wr_en;
  logic [1:0]       mode_wr_val;
  logic [DRV_W-1:0] drive_cmd;
  logic             tach_edge;
  logic             spin_active;
  logic             full_req;
  logic [DRV_W-1:0] drive_out;

  int checks = 0;
  int errs   = 0;
  int cur_mode;

  always #2 clk = ~clk;

  fan_spinup_seq #(.DRV_W(DRV_W), .TICK_DIV(DIV), .HALF_TICKS(HALF), .END_PULSES(2)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .strap_code  (strap_code),
    .mode_wr_en  (mode_wr_en),
    .mode_wr_val (mode_wr_val),
    .drive_cmd   (drive_cmd),
    .tach_edge   (tach_edge),
    .spin_active (spin_active),
    .full_req    (full_req),
    .drive_out   (drive_out)
  );

  function automatic int strap_mode(input int s);
    if (s == 0) return 0;
    if (s == 1) return 1;
    return 2;
  endfunction

  function automatic int exp_len(input int mode, input int k2, input int cut_k);
    int r;
    if (mode == 0) return 0;
    r = (mode == 1) ? HALF * DIV : (mode == 2) ? 2 * HALF * DIV : 4 * HALF * DIV;
    if (k2 > 0 && k2 < r)       r = k2;
    if (cut_k > 0 && cut_k < r) r = cut_k;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Counts override cycles after the start edge that follows the current negedge.
  task automatic measure(input int k1, input int k2, input int abort_k, input int zero_k,
                         output int cnt, output int bad);
    cnt = 0;
    bad = 0;
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      tach_edge  = 1'b0;
      mode_wr_en = 1'b0;
      if (spin_active) begin
        cnt++;
        if (drive_out != FULL || !full_req) bad++;
      end else if (drive_out != drive_cmd || full_req) bad++;
      tach_edge = ((i + 1) == k1) || ((i + 1) == k2);
      if ((i + 1) == abort_k) begin
        mode_wr_en  = 1'b1;
        mode_wr_val = 2'b00;
        cur_mode    = 0;
      end
      if ((i + 1) == zero_k) begin
        drive_cmd = '0;
        #1;
        chk(drive_out == '0 && !full_req, "R8 zero drive passes at once", int'(drive_out), 0);
      end
    end
    tach_edge  = 1'b0;
    mode_wr_en = 1'b0;
  endtask

  task automatic run_seq(input int mode, input int val, input int k1, input int k2,
                         input bit tach0, input int abort_k, input int zero_k, input string req);
    int cnt, bad, expc, mode_at_start;
    if (mode >= 0) begin
      @(negedge clk);
      mode_wr_en  = 1'b1;
      mode_wr_val = 2'(mode);
      cur_mode    = mode;
      @(negedge clk);
      mode_wr_en  = 1'b0;
    end
    mode_at_start = cur_mode;
    drive_cmd = DRV_W'(val);
    tach_edge = tach0;
    measure(k1, k2, abort_k, zero_k, cnt, bad);
    expc = exp_len(mode_at_start, k2, (abort_k > 0) ? abort_k : zero_k);
    chk(cnt == expc, req, cnt, expc);
    chk(bad == 0, "R3 drive output during and after override", bad, 0);
    drive_cmd = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic power_up(input int s, input int val);
    int cnt, bad, expc;
    rst_n      = 1'b0;
    strap_code = 2'(s);
    drive_cmd  = DRV_W'(val);
    repeat (3) @(negedge clk);
    chk(!spin_active && drive_out == drive_cmd, "R1 reset state", int'(spin_active), 0);
    rst_n    = 1'b1;
    cur_mode = strap_mode(s);
    measure(0, 0, 0, 0, cnt, bad);
    expc = exp_len(cur_mode, 0, 0);
    chk(cnt == expc, "R1 R2 strap sets power-up spin length", cnt, expc);
    chk(bad == 0, "R3 drive output after power-up", bad, 0);
    drive_cmd = '0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    checks++;
    errs++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int m, v, k1, k2;
    void'($urandom(32'd2718));
    rst_n       = 1'b0;
    strap_code  = 2'b00;
    mode_wr_en  = 1'b0;
    mode_wr_val = 2'b00;
    drive_cmd   = '0;
    tach_edge   = 1'b0;
    cur_mode    = 0;

    // R1 R2: power-up start under each strap code
    power_up(0, 300);
    power_up(1, 77);
    power_up(2, 511);
    power_up(3, 5);

    // R5: timeout length per mode, no tach
    run_seq(1, 100, 0, 0, 1'b0, 0, 0, "R5 timeout mode 01");
    run_seq(2, 100, 0, 0, 1'b0, 0, 0, "R5 timeout mode 10");
    run_seq(3, 100, 0, 0, 1'b0, 0, 0, "R5 timeout mode 11");

    // R6: mode off gives no override
    run_seq(0, 200, 3, 6, 1'b0, 0, 0, "R6 mode off no override");

    // R4: second tach ends it; a pulse on the start edge is ignored
    run_seq(3, 50, 4, 9, 1'b0, 0, 0, "R4 two tach pulses end override");
    run_seq(3, 50, 5, 11, 1'b1, 0, 0, "R4 tach on start edge not counted");

    // R9: timeout wins when the second pulse is late; tach wins at the boundary
    run_seq(1, 9, 10, HALF * DIV + 5, 1'b0, 0, 0, "R9 timeout before second tach");
    run_seq(1, 9, 10, HALF * DIV, 1'b0, 0, 0, "R9 tach and timeout same edge");

    // R7: write of 00 aborts, and the off mode then persists
    run_seq(2, 40, 0, 0, 1'b0, 7, 0, "R7 off write aborts override");
    run_seq(-1, 40, 0, 0, 1'b0, 0, 0, "R7 written off mode persists");

    // R8: drive falls to zero mid-sequence
    run_seq(3, 66, 0, 0, 1'b0, 0, 12, "R8 zero drive ends override");

    // R2: nonzero-to-nonzero change is not a start
    run_seq(1, 33, 0, 0, 1'b0, 0, 0, "R2 start before value change");
    drive_cmd = 9'd33;
    repeat (HALF * DIV + 2) @(negedge clk);
    drive_cmd = 9'd400;
    repeat (3) @(negedge clk);
    chk(!spin_active && drive_out == 9'd400, "R2 nonzero change is not a start",
        int'(spin_active), 0);
    drive_cmd = '0;
    repeat (2) @(negedge clk);

    // random mix
    for (int n = 0; n < 40; n++) begin
      m  = int'($urandom % 4);
      v  = 1 + int'($urandom % 511);
      k1 = 1 + int'($urandom % 60);
      k2 = (($urandom % 3) == 0) ? 0 : k1 + 1 + int'($urandom % 80);
      run_seq(m, v, k1, k2, 1'b0, 0, 0, "R9 random spin length");
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule